// File: doc/BRIEF.md
# Watchdog Timer with Guarded Control

A supervisory timer that counts machine cycles, each a fixed number of input clocks. If software does not restart it within the timeout, the block raises a sticky timeout flag. When it is enabled, it also pulses a reset to the CPU. Software reads and clears the flag through the status register's read strobe. After an expiry with the reset disabled, the flag is pinned high for a hold window, so polling software sees it before it can be cleared.

The enable and restart bits sit in a guarded control register. A write to that register only takes effect right after an unlock sequence on a separate unlock address: 0xAA, then 0x55 on the very next bus write. The unlock stays open for a bounded number of machine cycles. An external reset returns every piece of state to its initial value.

Top module: `wdog_ta`

## Requirements
- R1: A write to the control address (CTL_ADDR) is accepted only if all of the following hold. The two writes before it on the bus that went to the unlock address (TA_ADDR) were 0xAA and then 0x55, with no other write between those two. The write arrives within UNLOCK_MC*CLK_PER_MC clocks after the 0x55 write (the write at exactly that clock count is still accepted). No control write has been accepted since that 0x55. Writes to other addresses while the unlock is open leave it open.
- R2: Control data bit 1 is the enable and bit 0 requests a restart. The enable resets to 1 and changes only through an accepted control write.
- R3: The timeout flag rises exactly TIMEOUT_MC*CLK_PER_MC clocks after the last restart, external reset release, or end of a CPU reset pulse.
- R4: An accepted control write with bit 0 set clears the machine-cycle count and the prescaler. `wd_restart` is high for exactly the one cycle after that write. A restart that lands on the expiry clock wins, and no timeout occurs.
- R5: Every expiry sets `wd_flag`, whatever the enable. When a status read lands on the expiry clock, the flag is still set.
- R6: On expiry with the enable at 1, `cpu_rst` is high for exactly RST_MC*CLK_PER_MC cycles starting the cycle after expiry. During that time, counting is held at zero, bus writes and reads are ignored, and the flag is kept. Counting resumes from zero once the pulse ends.
- R7: On expiry with the enable at 0, `cpu_rst` stays low. For HOLD_CLKS clocks after expiry, status reads leave `wd_flag` at 1. The first read after that window clears it.
- R8: A restart during the hold window cancels the rest of the window, so the next status read clears the flag.
- R9: Active-low `rst_n` (asynchronous) clears the count, the hold window, the unlock state, the flag and `cpu_rst`, and sets the enable to 1.
- R10: A status read outside any hold window and outside a CPU reset pulse clears `wd_flag` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 8 | Register write data |
| stat_rd | input | 1 | Read strobe of the status register |
| cpu_rst | output | 1 | Reset pulse toward the CPU |
| wd_en | output | 1 | Enable bit |
| wd_restart | output | 1 | Restart bit, self-clearing |
| wd_flag | output | 1 | Sticky timeout flag |

## Verification
Expiry can coincide with a status read, and it can coincide with a restart. The bench times an unlock sequence so that the restart write lands on the exact clock of expiry. It then expects the flag to stay low and a fresh count to begin. The bench also places a status read on the expiry clock and expects the flag to be set. Random traffic hits both coincidences again, and a cycle-accurate bench model judges every output on every cycle.

// File: rtl/wdog_ta.sv
module wdog_ta #(
  parameter int          CLK_PER_MC = 12,
  parameter int          TIMEOUT_MC = 122880,
  parameter int          HOLD_CLKS  = 8192,
  parameter int          UNLOCK_MC  = 4,
  parameter int          RST_MC     = 2,
  parameter int          AW         = 8,
  parameter logic [AW-1:0] TA_ADDR  = 8'hE5,
  parameter logic [AW-1:0] CTL_ADDR = 8'hE6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          stat_rd,
  output logic          cpu_rst,
  output logic          wd_en,
  output logic          wd_restart,
  output logic          wd_flag
);
  localparam int WIN  = UNLOCK_MC * CLK_PER_MC;
  localparam int RLEN = RST_MC * CLK_PER_MC;
  localparam int PW   = (CLK_PER_MC > 1) ? $clog2(CLK_PER_MC) : 1;
  localparam int TW   = (TIMEOUT_MC > 1) ? $clog2(TIMEOUT_MC) : 1;
  localparam int HW   = $clog2(HOLD_CLKS + 1);
  localparam int WW   = $clog2(WIN + 1);
  localparam int RW   = $clog2(RLEN + 1);

  logic [PW-1:0] pre_cnt;
  logic [TW-1:0] tmo_cnt;
  logic [HW-1:0] hold_cnt;
  logic [WW-1:0] win_cnt;
  logic [RW-1:0] rst_cnt;
  logic          armed;

  logic busy, wr_ok, rd_ok, ta_wr, win_open, ctl_wr, restart, mc_tick, expire;
  logic hold_act, tmo_idle;

  assign busy     = rst_cnt != '0;
  assign wr_ok    = wr_en && !busy;
  assign rd_ok    = stat_rd && !busy;
  assign ta_wr    = wr_ok && (wr_addr == TA_ADDR);
  assign win_open = win_cnt != '0;
  assign ctl_wr   = wr_ok && (wr_addr == CTL_ADDR) && win_open;
  assign restart  = ctl_wr && wr_data[0];
  assign mc_tick  = pre_cnt == PW'(CLK_PER_MC - 1);
  assign expire   = !busy && !restart && mc_tick && (tmo_cnt == TW'(TIMEOUT_MC - 1));
  assign hold_act = hold_cnt != '0;
  assign tmo_idle = (tmo_cnt == '0) && (pre_cnt == '0);
  assign cpu_rst  = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      tmo_cnt <= '0;
    end else if (busy || restart) begin
      pre_cnt <= '0;
      tmo_cnt <= '0;
    end else if (mc_tick) begin
      pre_cnt <= '0;
      tmo_cnt <= (tmo_cnt == TW'(TIMEOUT_MC - 1)) ? '0 : tmo_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      win_cnt <= '0;
    end else if (busy) begin
      armed   <= 1'b0;
      win_cnt <= '0;
    end else begin
      if (wr_ok) armed <= ta_wr && (wr_data == 8'hAA);
      if (ta_wr && armed && (wr_data == 8'h55)) win_cnt <= WW'(WIN);
      else if (ta_wr || ctl_wr)                 win_cnt <= '0;
      else if (win_open)                        win_cnt <= win_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_en      <= 1'b1;
      wd_restart <= 1'b0;
    end else begin
      if (ctl_wr) wd_en <= wr_data[1];
      wd_restart <= restart;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rst_cnt <= '0;
    else if (expire && wd_en)  rst_cnt <= RW'(RLEN);
    else if (busy)             rst_cnt <= rst_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hold_cnt <= '0;
    else if (restart || busy)   hold_cnt <= '0;
    else if (expire)            hold_cnt <= wd_en ? '0 : HW'(HOLD_CLKS);
    else if (hold_act)          hold_cnt <= hold_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   wd_flag <= 1'b0;
    else if (expire)              wd_flag <= 1'b1;
    else if (rd_ok && !hold_act)  wd_flag <= 1'b0;
  end
endmodule

// File: rtl/wdog_ta_chk.sv
module wdog_ta_chk #(
  parameter int CLK_PER_MC = 12,
  parameter int RST_MC     = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cpu_rst,
  input logic wd_en,
  input logic wd_restart,
  input logic wd_flag,
  input logic hold_act,
  input logic win_open,
  input logic tmo_idle
);
  localparam int RLEN = RST_MC * CLK_PER_MC;
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (cpu_rst) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  AST_RST_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n) cpu_rst |-> hi_cnt < 16'(RLEN)); // R6
  AST_RST_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(cpu_rst) |-> hi_cnt == 16'(RLEN)); // R6
  AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) $rose(cpu_rst) |-> $past(wd_en)); // R6
  AST_COUNT_HELD:   assert property (@(posedge clk) disable iff (!rst_n) cpu_rst |=> tmo_idle); // R6
  AST_FLAG_ON_RST:  assert property (@(posedge clk) disable iff (!rst_n) $rose(cpu_rst) |-> wd_flag); // R5
  AST_HOLD_PINS:    assert property (@(posedge clk) disable iff (!rst_n) hold_act |=> wd_flag); // R7
  AST_RESTART_ONCE: assert property (@(posedge clk) disable iff (!rst_n) wd_restart |=> !wd_restart); // R4
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n) wd_restart |-> tmo_idle); // R4
  AST_EN_GUARDED:   assert property (@(posedge clk) disable iff (!rst_n) !$stable(wd_en) |-> $past(win_open)); // R2
endmodule

bind wdog_ta wdog_ta_chk #(.CLK_PER_MC(CLK_PER_MC), .RST_MC(RST_MC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rst(cpu_rst), .wd_en(wd_en),
  .wd_restart(wd_restart), .wd_flag(wd_flag), .hold_act(hold_act),
  .win_open(win_open), .tmo_idle(tmo_idle)
);

// File: tb/wdog_ta_test.sv
`timescale 1ns/1ps
module wdog_ta_test;
  localparam int K = 4, T = 16, H = 20, U = 2, RM = 2;
  localparam int TK = T * K, W = U * K, RL = RM * K;
  localparam logic [7:0] TA = 8'hE5, CTL = 8'hE6, OTH = 8'h10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, stat_rd = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic cpu_rst, wd_en, wd_restart, wd_flag;
  int vectors = 0, fails = 0;

  int  m_pre, m_tmo, m_win, m_rc, m_hold;
  bit  m_arm, m_en, m_rq, m_flag;

  always #2 clk = ~clk;

  wdog_ta #(.CLK_PER_MC(K), .TIMEOUT_MC(T), .HOLD_CLKS(H), .UNLOCK_MC(U), .RST_MC(RM),
            .AW(8), .TA_ADDR(TA), .CTL_ADDR(CTL)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stat_rd(stat_rd), .cpu_rst(cpu_rst), .wd_en(wd_en), .wd_restart(wd_restart), .wd_flag(wd_flag));

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input bit we, input logic [7:0] a, input logic [7:0] d, input bit rd, input bit rs_n);
    bit busy, wok, rok, ta, ctl, rs, tick, ex;
    int nwin;
    if (!rs_n) begin
      m_pre = 0; m_tmo = 0; m_win = 0; m_rc = 0; m_hold = 0;
      m_arm = 0; m_en = 1; m_rq = 0; m_flag = 0;
      return;
    end
    busy = m_rc != 0;
    wok  = we && !busy;
    rok  = rd && !busy;
    ta   = wok && a == TA;
    ctl  = wok && a == CTL && m_win != 0;
    rs   = ctl && d[0];
    tick = m_pre == K - 1;
    ex   = !busy && !rs && tick && m_tmo == T - 1;
    if (ex) m_flag = 1;
    else if (rok && m_hold == 0) m_flag = 0;
    if (rs || busy) m_hold = 0;
    else if (ex) m_hold = m_en ? 0 : H;
    else if (m_hold != 0) m_hold--;
    if (ex && m_en) m_rc = RL;
    else if (busy) m_rc--;
    if (busy || rs) begin m_pre = 0; m_tmo = 0; end
    else if (tick) begin m_pre = 0; m_tmo = (m_tmo == T - 1) ? 0 : m_tmo + 1; end
    else m_pre++;
    if (busy) begin m_arm = 0; m_win = 0; end
    else begin
      nwin = (m_win != 0) ? m_win - 1 : 0;
      if (ta && m_arm && d == 8'h55) nwin = W;
      else if (ta || ctl) nwin = 0;
      if (wok) m_arm = ta && d == 8'hAA;
      m_win = nwin;
    end
    if (ctl) m_en = d[1];
    m_rq = rs;
  endtask

  task automatic step(input bit we, input logic [7:0] a, input logic [7:0] d, input bit rd, input bit rs_n = 1'b1);
    @(negedge clk);
    rst_n = rs_n; wr_en = we; wr_addr = a; wr_data = d; stat_rd = rd;
    model(we, a, d, rd, rs_n);
    @(posedge clk); #1;
    chk("R2 enable vs model", wd_en, m_en);
    chk("R4 restart vs model", wd_restart, m_rq);
    chk("R6 cpu_rst vs model", cpu_rst, m_rc != 0);
    chk("R5 flag vs model", wd_flag, m_flag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, OTH, 8'h00, 0);
  endtask
  task automatic unlock();
    step(1, TA, 8'hAA, 0);
    step(1, TA, 8'h55, 0);
  endtask
  task automatic ctlw(input logic [7:0] d);
    step(1, CTL, d, 0);
  endtask
  task automatic rd1();
    step(0, OTH, 8'h00, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model(0, OTH, 0, 0, 0);
    repeat (2) @(posedge clk);
    #1;
    chk("R9 reset enable", wd_en, 1);
    chk("R9 reset flag", wd_flag, 0);
    chk("R9 reset cpu_rst", cpu_rst, 0);
    chk("R9 reset restart", wd_restart, 0);

    step(0, OTH, 8'h00, 0, 1'b1);
    ctlw(8'h00);                       chk("R2 locked write ignored", wd_en, 1);
    unlock(); ctlw(8'h00);             chk("R1 unlocked write sets enable 0", wd_en, 0);
    ctlw(8'h02);                       chk("R1 one write per unlock", wd_en, 0);
    step(1, TA, 8'hAA, 0); step(1, OTH, 8'h12, 0); step(1, TA, 8'h55, 0); ctlw(8'h02);
                                       chk("R1 broken sequence rejected", wd_en, 0);
    unlock(); idle(W); ctlw(8'h02);    chk("R1 late write rejected", wd_en, 0);
    unlock(); idle(W - 1); ctlw(8'h02); chk("R1 last window clock accepted", wd_en, 1);
    unlock(); ctlw(8'h00);             chk("R2 enable cleared", wd_en, 0);

    unlock(); ctlw(8'h01);             chk("R4 restart pulse", wd_restart, 1);
    idle(1);                           chk("R4 restart self-clears", wd_restart, 0);
    idle(TK - 2);                      chk("R3 no flag before timeout", wd_flag, 0);
    idle(1);                           chk("R3 flag at timeout", wd_flag, 1);
                                       chk("R7 no cpu reset when disabled", cpu_rst, 0);
    for (int i = 0; i < H; i++) rd1();
                                       chk("R7 reads ignored in hold", wd_flag, 1);
    rd1();                             chk("R10 read clears after hold", wd_flag, 0);

    unlock(); ctlw(8'h01); idle(TK);   chk("R7 flag set again", wd_flag, 1);
    unlock(); ctlw(8'h01); rd1();      chk("R8 restart cancels hold", wd_flag, 0);

    unlock(); ctlw(8'h01); idle(TK - 1);
    step(0, OTH, 8'h00, 1);            chk("R5 read on expiry clock loses", wd_flag, 1);

    unlock(); ctlw(8'h01); rd1();      chk("R8 flag cleared before race", wd_flag, 0);
    idle(TK - 4); unlock(); ctlw(8'h01);
                                       chk("R4 restart on expiry clock wins", wd_flag, 0);
                                       chk("R4 restart pulse in race", wd_restart, 1);

    unlock(); ctlw(8'h03); idle(TK - 1);
    step(0, OTH, 8'h00, 1);            chk("R6 cpu reset on expiry", cpu_rst, 1);
                                       chk("R5 flag with reset", wd_flag, 1);
    for (int i = 0; i < RL - 1; i++) step(0, OTH, 8'h00, 1);
                                       chk("R6 pulse still high", cpu_rst, 1);
                                       chk("R6 reads ignored during pulse", wd_flag, 1);
    idle(1);                           chk("R6 pulse ends", cpu_rst, 0);
    rd1();                             chk("R10 read clears flag", wd_flag, 0);
    idle(TK - 2);                      chk("R6 count restarted from zero", wd_flag, 0);
    idle(1);                           chk("R6 second expiry", cpu_rst, 1);
    idle(RL);

    unlock(); ctlw(8'h01); idle(TK);   chk("R7 flag before ext reset", wd_flag, 1);
    step(0, OTH, 8'h00, 0, 1'b0);      chk("R9 flag cleared", wd_flag, 0);
                                       chk("R9 enable restored", wd_en, 1);
    step(0, OTH, 8'h00, 0, 1'b1); idle(TK - 2);
                                       chk("R9 count cleared", wd_flag, 0);
    idle(1);                           chk("R9 expiry after release", cpu_rst, 1);
    idle(RL + 1);

    for (int n = 0; n < 1500; n++) begin
      int r;
      r = $urandom % 16;
      if (r < 5) idle(1 + $urandom % 90);
      else if (r < 9) begin
        unlock();
        idle($urandom % (W + 2));
        ctlw(8'($urandom % 4));
      end else if (r < 11) rd1();
      else if (r < 13) begin
        logic [7:0] a, d;
        a = ($urandom % 3 == 0) ? TA : (($urandom % 2) ? CTL : OTH);
        d = ($urandom % 3 == 0) ? 8'hAA : (($urandom % 2) ? 8'h55 : 8'($urandom));
        step(1, a, d, $urandom % 2);
      end else if (r == 13 && $urandom % 6 == 0) step(0, OTH, 8'h00, 0, 1'b0);
      else idle(1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule